// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block holds the privilege-state registers of a 32-bit core and moves the core into and out of the kernel. Each cycle it weighs three things: a sampled hardware interrupt, a synchronous exception reported by the pipeline, and either an exception-return request or a control-register access from privileged software. It then commits at most one action. An entry or a return also produces a registered redirect that tells the fetch unit where to go next.

On entry the block saves the current privilege level and interrupt enable into a previous-mode register. It drops to level 0 with interrupts off, records the trapping PC, the cause code and the sub-cause, and picks a target. A TLB refill uses its own vector. Every other cause uses the general vector. Address-related causes also capture the faulting address, and translation causes copy its page number into the entry-hi register. On return the saved mode and the return address are restored. After a refill the block also switches translation on, and the load-link bit is handled according to a keep-once flag. Software reads and writes the registers with a masked exchange, and only the writable bits change.

Top module: `xcpt_ctrl`

## Requirements
- R1: The interrupt lines are registered once into a status field. An interrupt is taken when (enable mask AND sampled status) is non-zero and the global IE bit is 1. A line whose enable bit is 0 causes no entry.
- R2: An entry copies PLV and IE into the previous-mode register and sets PLV=0 and IE=0. It writes commit_pc to the return-address register and records the code and subcode. The status register (index 3) reads as {1'b0, subcode[8:0], code[5:0], status[15:0]}.
- R3: One cycle after an entry decision, redirect_valid pulses. redirect_pc is {refill vector, 6'b0} when the code is 0x3F, and {general vector, 6'b0} otherwise.
- R4: For the codes 0x3F, 0x01, 0x02, 0x03, 0x04, 0x07, 0x08 and 0x09, a synchronous exception writes exc_vaddr into the bad-address register. Any other code leaves it unchanged.
- R5: For the codes 0x3F, 0x01, 0x02, 0x03, 0x04 and 0x07, exc_vaddr[31:13] is also written into the entry-hi page field (index 8, bits [31:13]).
- R6: A return at PLV0 restores PLV and IE from the previous-mode register and redirects to the return address one cycle later. If the recorded code is 0x3F, it also clears DA and sets PG.
- R7: A return with the keep flag set (index 9, bit 2) clears the flag and keeps the link bit. Without the keep flag, a return clears the link bit. llbit_set sets the link bit, which reads at index 9 bit 0.
- R8: A CSR access at PLV0 returns the old value and writes (wdata AND wmask) OR (old AND NOT wmask), limited to the writable bits. A CSR access or a return outside PLV0 does no access and takes an entry with code 0x0E.
- R9: When an interrupt and a synchronous exception are both present, the interrupt is taken with code 0 and subcode 0, and the bad-address register is left unchanged.
- R10: Reset gives PLV=0, IE=0, DA=1 and PG=0, with all other registers at zero.
- R11: The register indices and their writable fields are:
  - index 0, mode: {PG, DA, IE, PLV[1:0]} in bits [4:0];
  - index 1, previous mode: {PIE, PPLV[1:0]};
  - index 2, interrupt enable mask;
  - index 4, return address;
  - index 5, bad address;
  - index 6, general vector, bits [31:6];
  - index 7, refill vector, bits [31:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | IRQ_W | Hardware interrupt lines |
| commit_pc | input | 32 | PC of the instruction at the commit point |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 6 | Exception cause code |
| exc_subcode | input | 9 | Exception sub-cause |
| exc_vaddr | input | 32 | Faulting virtual address |
| ertn_req | input | 1 | Exception-return request |
| llbit_set | input | 1 | Sets the load-link bit |
| csr_req | input | 1 | Control-register access request |
| csr_we | input | 1 | Access also writes |
| csr_num | input | CSR_AW | Register index |
| csr_wdata | input | 32 | Write value |
| csr_wmask | input | 32 | Per-bit write mask |
| csr_rdata | output | 32 | Old value of the accessed register |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| cur_plv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Global interrupt enable |
| cur_da | output | 1 | Direct-address mode |
| cur_pg | output | 1 | Paged mode |
| llbit | output | 1 | Load-link bit |

## Verification
The assertions assume that a single instruction never raises a return and a control-register access in the same cycle. They also assume that a pipeline exception never uses code 0, since that code is reserved for interrupts, and that each request lasts one cycle. The stimulus issues every request for exactly one clock with all the others low. The only overlap it drives is an interrupt together with an exception, which is the case the priority rule defines. Exception codes come only from the listed cause set.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

    localparam int XLEN      = 32;
    localparam int ENTRY_LSB = 6;
    localparam int PAGE_LSB  = 13;
    localparam int CODE_W    = 6;
    localparam int SUB_W     = 9;

    localparam logic [CODE_W-1:0] EC_INT  = 6'h00;
    localparam logic [CODE_W-1:0] EC_PIL  = 6'h01;
    localparam logic [CODE_W-1:0] EC_PIS  = 6'h02;
    localparam logic [CODE_W-1:0] EC_PIF  = 6'h03;
    localparam logic [CODE_W-1:0] EC_PME  = 6'h04;
    localparam logic [CODE_W-1:0] EC_PPI  = 6'h07;
    localparam logic [CODE_W-1:0] EC_ADE  = 6'h08;
    localparam logic [CODE_W-1:0] EC_ALE  = 6'h09;
    localparam logic [CODE_W-1:0] EC_IPE  = 6'h0E;
    localparam logic [CODE_W-1:0] EC_TLBR = 6'h3F;

    localparam int unsigned CSR_MODE   = 0;
    localparam int unsigned CSR_PMODE  = 1;
    localparam int unsigned CSR_ECFG   = 2;
    localparam int unsigned CSR_ESTAT  = 3;
    localparam int unsigned CSR_ERA    = 4;
    localparam int unsigned CSR_BADV   = 5;
    localparam int unsigned CSR_EENTRY = 6;
    localparam int unsigned CSR_RENTRY = 7;
    localparam int unsigned CSR_EHI    = 8;
    localparam int unsigned CSR_LLCTL  = 9;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ENTRY,
        ACT_RETURN,
        ACT_CSR
    } act_e;

    typedef struct packed {
        logic       pg;
        logic       da;
        logic       ie;
        logic [1:0] plv;
    } mode_t;

    typedef struct packed {
        logic       pie;
        logic [1:0] pplv;
    } pmode_t;

    typedef struct packed {
        act_e              act;
        logic [CODE_W-1:0] code;
        logic [SUB_W-1:0]  sub;
        logic              fault_addr;
    } decision_t;

    function automatic logic takes_badv(input logic [CODE_W-1:0] c);
        case (c)
            EC_TLBR, EC_PIL, EC_PIS, EC_PIF, EC_PME, EC_PPI, EC_ADE, EC_ALE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic takes_vppn(input logic [CODE_W-1:0] c);
        case (c)
            EC_TLBR, EC_PIL, EC_PIS, EC_PIF, EC_PME, EC_PPI: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] writable_bits(input int unsigned idx, input int irq_w);
        case (idx)
            CSR_MODE:               return 32'h0000_001F;
            CSR_PMODE:              return 32'h0000_0007;
            CSR_ECFG:               return (32'h1 << irq_w) - 32'h1;
            CSR_ERA, CSR_BADV:      return 32'hFFFF_FFFF;
            CSR_EENTRY, CSR_RENTRY: return 32'hFFFF_FFC0;
            CSR_EHI:                return 32'hFFFF_E000;
            CSR_LLCTL:              return 32'h0000_0004;
            default:                return 32'h0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] masked_merge(input logic [XLEN-1:0] old_v,
                                                     input logic [XLEN-1:0] new_v,
                                                     input logic [XLEN-1:0] sw_mask,
                                                     input logic [XLEN-1:0] hw_mask);
        logic [XLEN-1:0] blended;
        blended = (new_v & sw_mask) | (old_v & ~sw_mask);
        return (old_v & ~hw_mask) | (blended & hw_mask);
    endfunction

endpackage

// File: rtl/xcpt_irq_detect.sv
module xcpt_irq_detect #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] irq_lines,
    input  logic [IRQ_W-1:0] lie,
    input  logic             gie,
    output logic [IRQ_W-1:0] is_q,
    output logic             pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_q <= '0;
        end else begin
            is_q <= irq_lines;
        end
    end

    assign pending = gie && (|(lie & is_q));

endmodule

// File: rtl/xcpt_arbiter.sv
module xcpt_arbiter
    import xcpt_pkg::*;
(
    input  logic              irq_pending,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [SUB_W-1:0]  exc_subcode,
    input  logic              ertn_req,
    input  logic              csr_req,
    input  logic [1:0]        plv,
    output decision_t         dec
);

    logic priv_fault;
    assign priv_fault = (ertn_req || csr_req) && (plv != 2'd0);

    always_comb begin
        dec.act        = ACT_NONE;
        dec.code       = EC_INT;
        dec.sub        = '0;
        dec.fault_addr = 1'b0;
        if (irq_pending) begin
            dec.act = ACT_ENTRY;
        end else if (exc_req) begin
            dec.act        = ACT_ENTRY;
            dec.code       = exc_code;
            dec.sub        = exc_subcode;
            dec.fault_addr = 1'b1;
        end else if (priv_fault) begin
            dec.act  = ACT_ENTRY;
            dec.code = EC_IPE;
        end else if (ertn_req) begin
            dec.act = ACT_RETURN;
        end else if (csr_req) begin
            dec.act = ACT_CSR;
        end
    end

endmodule

// File: rtl/xcpt_csr_regs.sv
module xcpt_csr_regs
    import xcpt_pkg::*;
#(
    parameter int IRQ_W  = 8,
    parameter int CSR_AW = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  decision_t                 dec,
    input  logic [XLEN-1:0]           commit_pc,
    input  logic [XLEN-1:0]           exc_vaddr,
    input  logic [IRQ_W-1:0]          is_q,
    input  logic                      llbit_set,
    input  logic                      csr_we,
    input  logic [CSR_AW-1:0]         csr_num,
    input  logic [XLEN-1:0]           csr_wdata,
    input  logic [XLEN-1:0]           csr_wmask,
    output logic [XLEN-1:0]           csr_rdata,
    output mode_t                     mode_q,
    output pmode_t                    pmode_q,
    output logic [IRQ_W-1:0]          lie_q,
    output logic [XLEN-1:ENTRY_LSB]   eentry_q,
    output logic [XLEN-1:ENTRY_LSB]   rentry_q,
    output logic [XLEN-1:0]           era_q,
    output logic                      link_q
);

    localparam int STAT_W = 16;

    logic [CODE_W-1:0]        ecode_q;
    logic [SUB_W-1:0]         esub_q;
    logic [XLEN-1:0]          badv_q;
    logic [XLEN-1:PAGE_LSB]   vppn_q;
    logic                     klo_q;

    int unsigned     sel;
    logic [XLEN-1:0] rd_word;
    logic [XLEN-1:0] new_word;
    logic            wr_en;

    assign sel = 32'(csr_num);

    always_comb begin
        case (sel)
            CSR_MODE:   rd_word = 32'(mode_q);
            CSR_PMODE:  rd_word = 32'(pmode_q);
            CSR_ECFG:   rd_word = 32'(lie_q);
            CSR_ESTAT:  rd_word = {1'b0, esub_q, ecode_q, STAT_W'(is_q)};
            CSR_ERA:    rd_word = era_q;
            CSR_BADV:   rd_word = badv_q;
            CSR_EENTRY: rd_word = {eentry_q, {ENTRY_LSB{1'b0}}};
            CSR_RENTRY: rd_word = {rentry_q, {ENTRY_LSB{1'b0}}};
            CSR_EHI:    rd_word = {vppn_q, {PAGE_LSB{1'b0}}};
            CSR_LLCTL:  rd_word = {29'b0, klo_q, 1'b0, link_q};
            default:    rd_word = '0;
        endcase
    end

    assign csr_rdata = (dec.act == ACT_CSR) ? rd_word : '0;
    assign wr_en     = (dec.act == ACT_CSR) && csr_we;
    assign new_word  = masked_merge(rd_word, csr_wdata, csr_wmask, writable_bits(sel, IRQ_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '{pg: 1'b0, da: 1'b1, ie: 1'b0, plv: 2'd0};
            pmode_q  <= '0;
            lie_q    <= '0;
            ecode_q  <= '0;
            esub_q   <= '0;
            era_q    <= '0;
            badv_q   <= '0;
            eentry_q <= '0;
            rentry_q <= '0;
            vppn_q   <= '0;
            klo_q    <= 1'b0;
            link_q   <= 1'b0;
        end else begin
            if (llbit_set) begin
                link_q <= 1'b1;
            end
            case (dec.act)
                ACT_ENTRY: begin
                    pmode_q    <= '{pie: mode_q.ie, pplv: mode_q.plv};
                    mode_q.plv <= 2'd0;
                    mode_q.ie  <= 1'b0;
                    era_q      <= commit_pc;
                    ecode_q    <= dec.code;
                    esub_q     <= dec.sub;
                    if (dec.fault_addr && takes_badv(dec.code)) begin
                        badv_q <= exc_vaddr;
                    end
                    if (dec.fault_addr && takes_vppn(dec.code)) begin
                        vppn_q <= exc_vaddr[XLEN-1:PAGE_LSB];
                    end
                end
                ACT_RETURN: begin
                    mode_q.plv <= pmode_q.pplv;
                    mode_q.ie  <= pmode_q.pie;
                    if (ecode_q == EC_TLBR) begin
                        mode_q.da <= 1'b0;
                        mode_q.pg <= 1'b1;
                    end
                    if (klo_q) begin
                        klo_q <= 1'b0;
                    end else begin
                        link_q <= 1'b0;
                    end
                end
                ACT_CSR: begin
                    if (wr_en) begin
                        case (sel)
                            CSR_MODE:   mode_q   <= mode_t'(new_word[4:0]);
                            CSR_PMODE:  pmode_q  <= pmode_t'(new_word[2:0]);
                            CSR_ECFG:   lie_q    <= new_word[IRQ_W-1:0];
                            CSR_ERA:    era_q    <= new_word;
                            CSR_BADV:   badv_q   <= new_word;
                            CSR_EENTRY: eentry_q <= new_word[XLEN-1:ENTRY_LSB];
                            CSR_RENTRY: rentry_q <= new_word[XLEN-1:ENTRY_LSB];
                            CSR_EHI:    vppn_q   <= new_word[XLEN-1:PAGE_LSB];
                            CSR_LLCTL:  klo_q    <= new_word[2];
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xcpt_redirect.sv
module xcpt_redirect
    import xcpt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  decision_t               dec,
    input  logic [XLEN-1:ENTRY_LSB] eentry,
    input  logic [XLEN-1:ENTRY_LSB] rentry,
    input  logic [XLEN-1:0]         era,
    output logic                    redirect_valid,
    output logic [XLEN-1:0]         redirect_pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= (dec.act == ACT_ENTRY) || (dec.act == ACT_RETURN);
            case (dec.act)
                ACT_ENTRY:  redirect_pc <= (dec.code == EC_TLBR) ? {rentry, {ENTRY_LSB{1'b0}}}
                                                                 : {eentry, {ENTRY_LSB{1'b0}}};
                ACT_RETURN: redirect_pc <= era;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xcpt_ctrl.sv
module xcpt_ctrl
    import xcpt_pkg::*;
#(
    parameter int IRQ_W  = 8,
    parameter int CSR_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IRQ_W-1:0]  irq_lines,
    input  logic [31:0]       commit_pc,
    input  logic              exc_req,
    input  logic [5:0]        exc_code,
    input  logic [8:0]        exc_subcode,
    input  logic [31:0]       exc_vaddr,
    input  logic              ertn_req,
    input  logic              llbit_set,
    input  logic              csr_req,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_num,
    input  logic [31:0]       csr_wdata,
    input  logic [31:0]       csr_wmask,
    output logic [31:0]       csr_rdata,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc,
    output logic [1:0]        cur_plv,
    output logic              cur_ie,
    output logic              cur_da,
    output logic              cur_pg,
    output logic              llbit
);

    decision_t               dec;
    mode_t                   mode_q;
    pmode_t                  pmode_q;
    logic [IRQ_W-1:0]        lie_q;
    logic [IRQ_W-1:0]        is_q;
    logic                    irq_pending;
    logic [XLEN-1:ENTRY_LSB] eentry_q;
    logic [XLEN-1:ENTRY_LSB] rentry_q;
    logic [XLEN-1:0]         era_q;

    xcpt_irq_detect #(.IRQ_W(IRQ_W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .lie       (lie_q),
        .gie       (mode_q.ie),
        .is_q      (is_q),
        .pending   (irq_pending)
    );

    xcpt_arbiter u_arb (
        .irq_pending (irq_pending),
        .exc_req     (exc_req),
        .exc_code    (exc_code),
        .exc_subcode (exc_subcode),
        .ertn_req    (ertn_req),
        .csr_req     (csr_req),
        .plv         (mode_q.plv),
        .dec         (dec)
    );

    xcpt_csr_regs #(.IRQ_W(IRQ_W), .CSR_AW(CSR_AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .commit_pc (commit_pc),
        .exc_vaddr (exc_vaddr),
        .is_q      (is_q),
        .llbit_set (llbit_set),
        .csr_we    (csr_we),
        .csr_num   (csr_num),
        .csr_wdata (csr_wdata),
        .csr_wmask (csr_wmask),
        .csr_rdata (csr_rdata),
        .mode_q    (mode_q),
        .pmode_q   (pmode_q),
        .lie_q     (lie_q),
        .eentry_q  (eentry_q),
        .rentry_q  (rentry_q),
        .era_q     (era_q),
        .link_q    (llbit)
    );

    xcpt_redirect u_redir (
        .clk            (clk),
        .rst            (rst),
        .dec            (dec),
        .eentry         (eentry_q),
        .rentry         (rentry_q),
        .era            (era_q),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    assign cur_plv = mode_q.plv;
    assign cur_ie  = mode_q.ie;
    assign cur_da  = mode_q.da;
    assign cur_pg  = mode_q.pg;

endmodule

// File: rtl/xcpt_ctrl_chk.sv
module xcpt_ctrl_chk
    import xcpt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input act_e              dec_act,
    input logic [CODE_W-1:0] dec_code,
    input logic              irq_pend,
    input logic              exc_req,
    input logic              csr_req,
    input logic              ertn_req,
    input logic [1:0]        cur_plv,
    input logic              cur_ie,
    input logic              cur_da,
    input logic              cur_pg,
    input logic [1:0]        prev_plv,
    input logic              prev_ie,
    input logic              redirect_valid,
    input logic [31:0]       redirect_pc
);

    p_reset_mode_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_plv == 2'd0 && !cur_ie && cur_da && !cur_pg));

    p_entry_kernel_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_act == ACT_ENTRY) |=> (cur_plv == 2'd0 && !cur_ie && redirect_valid));

    p_entry_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_act == ACT_ENTRY) |=> (redirect_pc[5:0] == 6'd0));

    p_return_restore_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_act == ACT_RETURN) |=> (redirect_valid && cur_plv == $past(prev_plv)
                                     && cur_ie == $past(prev_ie)));

    p_irq_first_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_pend && exc_req) |-> (dec_act == ACT_ENTRY && dec_code == EC_INT));

    p_priv_fault_r8: assert property (@(posedge clk) disable iff (rst)
        ((csr_req || ertn_req) && cur_plv != 2'd0 && !irq_pend && !exc_req)
            |-> (dec_act == ACT_ENTRY && dec_code == EC_IPE));

endmodule

bind xcpt_ctrl xcpt_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .dec_act        (dec.act),
    .dec_code       (dec.code),
    .irq_pend       (irq_pending),
    .exc_req        (exc_req),
    .csr_req        (csr_req),
    .ertn_req       (ertn_req),
    .cur_plv        (cur_plv),
    .cur_ie         (cur_ie),
    .cur_da         (cur_da),
    .cur_pg         (cur_pg),
    .prev_plv       (pmode_q.pplv),
    .prev_ie        (pmode_q.pie),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
);

// File: tb/tb_xcpt_ctrl.sv
module tb_xcpt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_W      = 8;
    localparam int CSR_AW     = 4;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [IRQ_W-1:0]  irq_lines = '0;
    logic [31:0]       commit_pc = '0;
    logic              exc_req = 1'b0;
    logic [5:0]        exc_code = '0;
    logic [8:0]        exc_subcode = '0;
    logic [31:0]       exc_vaddr = '0;
    logic              ertn_req = 1'b0;
    logic              llbit_set = 1'b0;
    logic              csr_req = 1'b0;
    logic              csr_we = 1'b0;
    logic [CSR_AW-1:0] csr_num = '0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_wmask = '0;
    logic [31:0]       csr_rdata;
    logic              redirect_valid;
    logic [31:0]       redirect_pc;
    logic [1:0]        cur_plv;
    logic              cur_ie, cur_da, cur_pg, llbit;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    xcpt_ctrl #(.IRQ_W(IRQ_W), .CSR_AW(CSR_AW)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mode_word();
        return {27'b0, cur_pg, cur_da, cur_ie, cur_plv};
    endfunction

    // Monitor: pops one expected redirect target per redirect pulse (R3, R6)
    always @(negedge clk) begin
        if (!rst && redirect_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected redirect", redirect_pc, 32'hxxxx_xxxx);
            end else begin
                check("R3 redirect target", redirect_pc, exp_q.pop_front());
            end
        end
    end

    task automatic csr_op(input logic [3:0] idx, input logic we, input logic [31:0] wd,
                          input logic [31:0] wm, output logic [31:0] rd);
        @(negedge clk);
        csr_req = 1'b1; csr_we = we; csr_num = idx; csr_wdata = wd; csr_wmask = wm;
        #1 rd = csr_rdata;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    task automatic csr_wr(input logic [3:0] idx, input logic [31:0] wd);
        logic [31:0] unused_rd;
        csr_op(idx, 1'b1, wd, 32'hFFFF_FFFF, unused_rd);
    endtask

    task automatic csr_rd_check(input string req, input logic [3:0] idx, input logic [31:0] exp);
        logic [31:0] rd;
        csr_op(idx, 1'b0, 32'h0, 32'h0, rd);
        check(req, rd, exp);
    endtask

    task automatic raise(input logic [5:0] code, input logic [8:0] sub,
                         input logic [31:0] pc, input logic [31:0] va);
        @(negedge clk);
        exc_req = 1'b1; exc_code = code; exc_subcode = sub; commit_pc = pc; exc_vaddr = va;
        @(negedge clk);
        exc_req = 1'b0;
    endtask

    task automatic do_ertn(input logic [31:0] pc);
        @(negedge clk);
        ertn_req = 1'b1; commit_pc = pc;
        @(negedge clk);
        ertn_req = 1'b0;
    endtask

    task automatic pulse_link();
        @(negedge clk);
        llbit_set = 1'b1;
        @(negedge clk);
        llbit_set = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset mode {pg,da,ie,plv} = 0_1_0_00
        check("R10 reset mode", mode_word(), 32'h08);
        check("R10 reset link", {31'b0, llbit}, 32'h0);
        csr_rd_check("R11 mode index 0", 4'd0, 32'h08);

        // R8: only bits [31:6] of the general vector are writable
        csr_wr(4'd6, 32'hFFFF_FFFF);
        csr_rd_check("R8 writable vector bits", 4'd6, 32'hFFFF_FFC0);
        csr_wr(4'd6, 32'h8000_0100);
        csr_wr(4'd7, 32'h9000_0200);
        csr_rd_check("R11 refill vector index 7", 4'd7, 32'h9000_0200);

        // R8: masked exchange returns old value
        csr_wr(4'd4, 32'h1234_5678);
        csr_op(4'd4, 1'b1, 32'hFFFF_0000, 32'h00FF_00FF, rd);
        check("R8 exchange old value", rd, 32'h1234_5678);
        csr_rd_check("R8 exchange merge", 4'd4, 32'h12FF_5600);

        // R7: link bit set and visible
        pulse_link();
        csr_rd_check("R7 link visible", 4'd9, 32'h1);

        // PLV3, IE=1, DA=1
        csr_wr(4'd0, 32'h0F);
        check("R11 mode write", mode_word(), 32'h0F);

        // R8: access outside PLV0 takes IPE entry, write dropped
        exp_q.push_back(32'h8000_0100);
        commit_pc = 32'h2000;
        csr_op(4'd2, 1'b1, 32'hFF, 32'hFFFF_FFFF, rd);
        check("R2 kernel mode after entry", mode_word(), 32'h08);
        csr_rd_check("R8 blocked write left mask", 4'd2, 32'h0);
        csr_rd_check("R2 previous mode saved", 4'd1, 32'h7);
        csr_rd_check("R2 return address", 4'd4, 32'h2000);
        csr_rd_check("R8 IPE code", 4'd3, 32'h000E_0000);

        // R6/R7: return restores PLV3 IE1, clears link without keep flag
        exp_q.push_back(32'h2000);
        do_ertn(32'h3000);
        check("R6 restored mode", mode_word(), 32'h0F);
        check("R7 link cleared", {31'b0, llbit}, 32'h0);

        // R4/R5: page-invalid load
        exp_q.push_back(32'h8000_0100);
        raise(6'h01, 9'd0, 32'h400, 32'hABCD_E123);
        csr_rd_check("R4 bad address written", 4'd5, 32'hABCD_E123);
        csr_rd_check("R5 page field written", 4'd8, 32'hABCD_E000);

        // R4: system call leaves bad address
        exp_q.push_back(32'h8000_0100);
        raise(6'h0B, 9'd0, 32'h404, 32'h0000_5555);
        csr_rd_check("R4 bad address kept", 4'd5, 32'hABCD_E123);

        // R4/R5/R2: address error with subcode 1
        exp_q.push_back(32'h8000_0100);
        raise(6'h08, 9'd1, 32'h408, 32'h8000_1000);
        csr_rd_check("R4 address error bad address", 4'd5, 32'h8000_1000);
        csr_rd_check("R5 page field kept", 4'd8, 32'hABCD_E000);
        csr_rd_check("R2 code and subcode", 4'd3, 32'h0048_0000);

        // R3/R5: refill uses its own vector
        exp_q.push_back(32'h9000_0200);
        raise(6'h3F, 9'd0, 32'h500, 32'h7777_3ABC);
        csr_rd_check("R5 refill page field", 4'd8, 32'h7777_2000);

        // R6/R7: return after refill with keep flag
        csr_wr(4'd9, 32'h4);
        pulse_link();
        exp_q.push_back(32'h500);
        do_ertn(32'h600);
        check("R6 refill return mode", mode_word(), 32'h10);
        check("R7 link kept", {31'b0, llbit}, 32'h1);
        csr_rd_check("R7 keep flag cleared", 4'd9, 32'h1);
        exp_q.push_back(32'h500);
        do_ertn(32'h604);
        check("R7 link cleared second return", {31'b0, llbit}, 32'h0);

        // R1: masked line causes no entry
        csr_wr(4'd2, 32'h05);
        csr_wr(4'd0, 32'h14);
        @(negedge clk);
        irq_lines = 8'h02;
        repeat (4) @(negedge clk);
        check("R1 masked line no entry", mode_word(), 32'h14);

        // R9/R1: interrupt beats simultaneous exception
        exp_q.push_back(32'h8000_0100);
        irq_lines = 8'h04;
        @(negedge clk);
        exc_req = 1'b1; exc_code = 6'h01; exc_subcode = 9'd0;
        commit_pc = 32'h700; exc_vaddr = 32'h0000_1111;
        @(negedge clk);
        exc_req = 1'b0;
        check("R1 interrupt entry mode", mode_word(), 32'h10);
        csr_rd_check("R9 interrupt code 0", 4'd3, 32'h0000_0004);
        csr_rd_check("R9 bad address untouched", 4'd5, 32'h7777_3ABC);
        csr_rd_check("R2 interrupt return address", 4'd4, 32'h700);
        irq_lines = '0;

        // R8: return outside PLV0 takes IPE entry
        csr_wr(4'd0, 32'h13);
        exp_q.push_back(32'h8000_0100);
        do_ertn(32'h800);
        check("R8 privileged return fault mode", mode_word(), 32'h10);
        csr_rd_check("R8 privileged return code", 4'd3, 32'h000E_0000);

        repeat (3) @(negedge clk);
        check("R3 all redirects seen", exp_q.size(), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule